// File: doc/BRIEF.md
# Dynamic-Threshold ReLU Activation Unit

This unit applies a rectifier whose clamp level is not zero but a statistic of the vector being activated. A layer's pre-activation sums arrive as a stream of `N` signed fixed-point values, bracketed by a start marker and an end marker. While the vector streams in, the unit keeps a running minimum, maximum and sum and stores every value in a local register array. When the vector is complete, the unit derives one threshold from it: either the midpoint of its range or its arithmetic mean, chosen at build time.

Starting on the cycle after the final element is taken, the unit replays the stored values in arrival order. Each value below the threshold is raised to the threshold and flagged with a zero derivative. Each value at or above it passes unchanged with a derivative flag of one, which is the slope a training datapath needs for backpropagation. Every new vector gets a freshly computed threshold, and all elements of that vector share it. The data width is a parameter, so 4-, 5-, 6- and 8-bit builds come from the same source.

Top module: `dyn_thresh_relu`

## Requirements
- R1: With MODE = THR_MIDRANGE the threshold is floor((min + max) / 2) over the current vector, using an arithmetic right shift. For example, a vector spanning -4 to 8 gives 2, and one spanning -5 to 0 gives -3.
- R2: With MODE = THR_MEAN the threshold is floor(sum / N), rounded toward negative infinity, for any N. A power-of-two N uses a shift and any other N uses an exact reciprocal multiply.
- R3: An element strictly below the threshold is emitted as the threshold value with out_deriv = 0.
- R4: An element at or above the threshold is emitted unchanged with out_deriv = 1.
- R5: Results leave in arrival order. out_valid is high for exactly N consecutive cycles, and the first of them is the cycle after the clock edge that takes the final element.
- R6: The threshold is recomputed for every vector, and out_thresh holds one value for the whole emission of a vector.
- R7: An element with in_first = 1 begins a new vector at index 0 and discards any partly collected one.
- R8: A vector is taken only if in_last = 1 arrives on exactly its Nth element. An early in_last, or an Nth element without in_last, discards the vector with no output. While waiting for a vector, elements with in_first = 0 are ignored.
- R9: Inputs presented while results are being emitted are ignored.
- R10: With N = 1 the threshold equals the single element, which is emitted unchanged with out_deriv = 1.
- R11: After reset out_valid is 0 and the unit waits for an element with in_first = 1.
- R12: The sum accumulator is DATA_W + clog2(N) bits wide and cannot overflow. Vectors made entirely of the most negative value, or entirely of the most positive value, give that value as their mean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input element present |
| in_first | input | 1 | Element is the first of a vector |
| in_last | input | 1 | Element is the last of a vector |
| in_data | input | DATA_W | Signed pre-activation value |
| out_valid | output | 1 | Activated element present |
| out_data | output | DATA_W | Signed activated value |
| out_deriv | output | 1 | Derivative flag: 1 when the element is at or above the threshold |
| out_thresh | output | DATA_W | Threshold of the vector being emitted |

## Verification
The hardest situation to reach from the ports is input arriving while results are still being emitted. The bench places a complete, well-formed vector on the inputs during every emission cycle of the previous one, so any leak would show up as extra output bursts or corrupted replay data. Malformed framing is also awkward to reach: an early end marker, a missing end marker, and elements without a start marker while idle. The bench drives each of these and confirms that no output appears and that the next good vector is handled correctly. The non-power-of-two mean path is driven with negative sums that are not multiples of N, so truncation toward negative infinity is checked rather than truncation toward zero.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  typedef enum logic {
    THR_MIDRANGE = 1'b0,
    THR_MEAN     = 1'b1
  } thr_mode_e;

  typedef enum logic [1:0] {
    ST_WAIT    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_EMIT    = 2'd2
  } unit_state_e;
endpackage

// File: rtl/dtr_stats.sv
module dtr_stats #(
  parameter int DATA_W = 8,
  parameter int SUM_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd,
  input  logic                     restart,
  input  logic signed [DATA_W-1:0] x,
  output logic signed [DATA_W-1:0] min_q,
  output logic signed [DATA_W-1:0] max_q,
  output logic signed [SUM_W-1:0]  sum_q
);
  logic signed [DATA_W-1:0] min_d, max_d;
  logic signed [SUM_W-1:0]  sum_d, x_ext;

  assign x_ext = SUM_W'(x);

  always_comb begin
    if (restart) begin
      min_d = x;
      max_d = x;
      sum_d = x_ext;
    end else begin
      min_d = (x < min_q) ? x : min_q;
      max_d = (x > max_q) ? x : max_q;
      sum_d = sum_q + x_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= '0;
      max_q <= '0;
      sum_q <= '0;
    end else if (upd) begin
      min_q <= min_d;
      max_q <= max_d;
      sum_q <= sum_d;
    end
  end

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && restart) |=> (min_q == max_q && sum_q == SUM_W'(min_q)));

  // R12
  min_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    min_q <= max_q);
endmodule

// File: rtl/dtr_thresh.sv
module dtr_thresh
  import dtr_pkg::*;
#(
  parameter int        DATA_W = 8,
  parameter int        N      = 16,
  parameter int        SUM_W  = 12,
  parameter thr_mode_e MODE   = THR_MEAN
) (
  input  logic signed [DATA_W-1:0] min_v,
  input  logic signed [DATA_W-1:0] max_v,
  input  logic signed [SUM_W-1:0]  sum_v,
  output logic signed [DATA_W-1:0] thr
);
  localparam int LOG2N   = $clog2(N);
  localparam bit IS_POW2 = ((1 << LOG2N) == N);

  generate
    if (MODE == THR_MIDRANGE) begin : g_mid
      logic signed [DATA_W:0] span_sum;
      assign span_sum = {min_v[DATA_W-1], min_v} + {max_v[DATA_W-1], max_v};
      assign thr      = span_sum[DATA_W:1];
    end else if (IS_POW2) begin : g_mean_shift
      assign thr = sum_v[LOG2N +: DATA_W];
    end else begin : g_mean_recip
      localparam int FRAC = SUM_W + LOG2N + 1;
      localparam int PW   = SUM_W + FRAC + 2;
      localparam logic [SUM_W:0] BIAS  = (SUM_W+1)'(N) << (DATA_W - 1);
      localparam logic [FRAC:0]  RECIP =
        (FRAC+1)'(((64'd1 << FRAC) + 64'(N) - 64'd1) / 64'(N));
      logic [SUM_W:0]  sum_b;
      logic [PW-1:0]   prod;
      logic [DATA_W-1:0] quo;
      assign sum_b = {sum_v[SUM_W-1], sum_v} + BIAS;
      assign prod  = PW'(sum_b) * PW'(RECIP);
      assign quo   = prod[FRAC +: DATA_W];
      assign thr   = {~quo[DATA_W-1], quo[DATA_W-2:0]};
    end
  endgenerate
endmodule

// File: rtl/dtr_vec_buf.sv
module dtr_vec_buf #(
  parameter int DATA_W = 8,
  parameter int N      = 16,
  parameter int IDXW   = 4
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [IDXW-1:0]          wr_idx,
  input  logic signed [DATA_W-1:0] wr_data,
  input  logic [IDXW-1:0]          rd_idx,
  output logic signed [DATA_W-1:0] rd_data
);
  logic signed [DATA_W-1:0] mem [N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_ent
      always_ff @(posedge clk) begin
        if (wr_en && wr_idx == IDXW'(i)) mem[i] <= wr_data;
      end
    end
  endgenerate

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/dtr_clamp.sv
module dtr_clamp #(
  parameter int DATA_W = 8
) (
  input  logic signed [DATA_W-1:0] x,
  input  logic signed [DATA_W-1:0] thr,
  output logic signed [DATA_W-1:0] y,
  output logic                     at_or_above
);
  always_comb begin
    at_or_above = (x >= thr);
    y           = at_or_above ? x : thr;
  end
endmodule

// File: rtl/dyn_thresh_relu.sv
module dyn_thresh_relu
  import dtr_pkg::*;
#(
  parameter int        DATA_W = 8,
  parameter int        N      = 16,
  parameter thr_mode_e MODE   = THR_MEAN
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_first,
  input  logic                     in_last,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data,
  output logic                     out_deriv,
  output logic signed [DATA_W-1:0] out_thresh
);
  localparam int LOG2N = $clog2(N);
  localparam int IDXW  = (N > 1) ? LOG2N : 1;
  localparam int SUM_W = DATA_W + LOG2N;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(N - 1);

  unit_state_e state_q, state_d;
  logic [IDXW-1:0] cnt_q, cnt_d, rd_q, rd_d, idx;
  logic accept, at_end;
  logic signed [DATA_W-1:0] min_q, max_q, rd_data;
  logic signed [SUM_W-1:0]  sum_q;

  always_comb begin
    unique case (state_q)
      ST_WAIT:    accept = in_valid && in_first;
      ST_COLLECT: accept = in_valid;
      default:    accept = 1'b0;
    endcase
    idx     = in_first ? '0 : cnt_q;
    at_end  = (idx == LAST_IDX);
    state_d = state_q;
    cnt_d   = cnt_q;
    rd_d    = rd_q;
    if (state_q == ST_EMIT) begin
      if (rd_q == LAST_IDX) begin
        state_d = ST_WAIT;
        rd_d    = '0;
      end else begin
        rd_d = rd_q + 1'b1;
      end
    end else if (accept) begin
      if (in_last && at_end) begin
        state_d = ST_EMIT;
      end else if (in_last || at_end) begin
        state_d = ST_WAIT;
      end else begin
        state_d = ST_COLLECT;
        cnt_d   = idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept)              cnt_q <= cnt_d;
      if (state_q == ST_EMIT)  rd_q  <= rd_d;
    end
  end

  dtr_stats #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .upd(accept), .restart(idx == '0),
    .x(in_data), .min_q(min_q), .max_q(max_q), .sum_q(sum_q)
  );

  dtr_vec_buf #(.DATA_W(DATA_W), .N(N), .IDXW(IDXW)) u_buf (
    .clk(clk), .wr_en(accept), .wr_idx(idx), .wr_data(in_data),
    .rd_idx(rd_q), .rd_data(rd_data)
  );

  dtr_thresh #(.DATA_W(DATA_W), .N(N), .SUM_W(SUM_W), .MODE(MODE)) u_thr (
    .min_v(min_q), .max_v(max_q), .sum_v(sum_q), .thr(out_thresh)
  );

  dtr_clamp #(.DATA_W(DATA_W)) u_clamp (
    .x(rd_data), .thr(out_thresh), .y(out_data), .at_or_above(out_deriv)
  );

  assign out_valid = (state_q == ST_EMIT);

  // R5
  emit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_last && at_end) |=> (out_valid && rd_q == '0));

  // R5
  emit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> ($past(rd_q) == LAST_IDX));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_last != at_end)) |=> !out_valid);

  // R6
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(out_thresh));

  // R9
  emit_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> ($stable(min_q) && $stable(max_q) && $stable(sum_q)));

  // R3
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_deriv) |-> (out_data == out_thresh));

  // R4
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data >= out_thresh));

  // R1 R2
  thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_thresh >= min_q && out_thresh <= max_q));
endmodule

// File: tb/tb_dyn_thresh_relu.sv
module tb_dyn_thresh_relu;
  import dtr_pkg::*;

  typedef struct {
    int    data;
    bit    deriv;
    int    thr;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic              in_valid [3];
  logic              in_first [3];
  logic              in_last  [3];
  logic signed [7:0] in_data  [3];
  logic              out_valid [3];
  logic              out_deriv [3];
  logic signed [7:0] out_data  [3];
  logic signed [7:0] out_thr   [3];
  logic signed [4:0] od2, ot2;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  exp_t sb [3][$];

  // unit 0: mean, N=6 (reciprocal path); unit 1: midrange, N=4; unit 2: mean, N=1, 5-bit
  dyn_thresh_relu #(.DATA_W(8), .N(6), .MODE(THR_MEAN)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid[0]), .in_first(in_first[0]),
    .in_last(in_last[0]), .in_data(in_data[0]), .out_valid(out_valid[0]),
    .out_data(out_data[0]), .out_deriv(out_deriv[0]), .out_thresh(out_thr[0]));

  dyn_thresh_relu #(.DATA_W(8), .N(4), .MODE(THR_MIDRANGE)) dut_mr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid[1]), .in_first(in_first[1]),
    .in_last(in_last[1]), .in_data(in_data[1]), .out_valid(out_valid[1]),
    .out_data(out_data[1]), .out_deriv(out_deriv[1]), .out_thresh(out_thr[1]));

  dyn_thresh_relu #(.DATA_W(5), .N(1), .MODE(THR_MEAN)) dut_one (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid[2]), .in_first(in_first[2]),
    .in_last(in_last[2]), .in_data(in_data[2][4:0]), .out_valid(out_valid[2]),
    .out_data(od2), .out_deriv(out_deriv[2]), .out_thresh(ot2));

  assign out_data[2] = 8'(od2);
  assign out_thr[2]  = 8'(ot2);

  function automatic int unit_n(int u);
    return (u == 0) ? 6 : (u == 1) ? 4 : 1;
  endfunction

  function automatic int floor_div(int a, int b);
    int q = a / b;
    if ((a % b) != 0 && a < 0) q = q - 1;
    return q;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic expect_vec(int u, int vals[$], string tag);
    int mn = vals[0], mx = vals[0], s = 0, thr;
    exp_t e;
    foreach (vals[i]) begin
      if (vals[i] < mn) mn = vals[i];
      if (vals[i] > mx) mx = vals[i];
      s += vals[i];
    end
    thr = (u == 1) ? ((mn + mx) >>> 1) : floor_div(s, vals.size());
    foreach (vals[i]) begin
      e.thr   = thr;
      e.deriv = (vals[i] >= thr);
      e.data  = e.deriv ? vals[i] : thr;
      e.tag   = tag;
      sb[u].push_back(e);
    end
  endtask

  task automatic drive_vec(int u, int vals[$], bit use_first, int last_at);
    foreach (vals[i]) begin
      @(negedge clk);
      in_valid[u] = 1'b1;
      in_first[u] = use_first && (i == 0);
      in_last[u]  = (i == last_at);
      in_data[u]  = 8'(vals[i]);
    end
  endtask

  task automatic finish_vec(int u, bit start_exp, string tag);
    @(negedge clk);
    chk(out_valid[u] == start_exp, tag, int'(out_valid[u]), int'(start_exp));
    in_valid[u] = 1'b0;
    in_first[u] = 1'b0;
    in_last[u]  = 1'b0;
  endtask

  task automatic drain(int u, string tag);
    repeat (unit_n(u) + 3) @(negedge clk);
    chk(sb[u].size() == 0, tag, sb[u].size(), 0);
  endtask

  task automatic run_vec(int u, int vals[$], string tag);
    expect_vec(u, vals, tag);
    drive_vec(u, vals, 1'b1, vals.size() - 1);
    finish_vec(u, 1'b1, "R5 start");
    drain(u, "R5 length");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int u = 0; u < 3; u++) begin
        if (out_valid[u]) begin
          exp_t e;
          if (sb[u].size() == 0) begin
            chk(1'b0, "R5/R8/R9 unexpected output", out_data[u], 0);
          end else begin
            e = sb[u].pop_front();
            chk(out_data[u] == e.data, {e.tag, " data"}, out_data[u], e.data);
            chk(out_deriv[u] == e.deriv, {e.tag, " deriv"}, int'(out_deriv[u]), int'(e.deriv));
            chk(out_thr[u] == e.thr, {e.tag, " thresh"}, out_thr[u], e.thr);
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    for (int u = 0; u < 3; u++) begin
      in_valid[u] = 1'b0; in_first[u] = 1'b0; in_last[u] = 1'b0; in_data[u] = '0;
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    for (int u = 0; u < 3; u++) chk(out_valid[u] == 1'b0, "R11 reset", int'(out_valid[u]), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int u = 0; u < 3; u++) chk(out_valid[u] == 1'b0, "R11 idle", int'(out_valid[u]), 0);

    // R1 midrange
    run_vec(1, '{-4, 8, 0, 3}, "R1 midrange");
    run_vec(1, '{-5, 0, -2, -1}, "R1 floor");
    // R6 recomputed per vector
    run_vec(1, '{10, 20, 30, 40}, "R6 new threshold");

    // R2 mean, non-power-of-two N, R3/R4 clamp and pass
    run_vec(0, '{1, 2, 3, 4, 5, 6}, "R2 mean");
    run_vec(0, '{-1, -1, -1, -1, -1, 0}, "R2 negative floor");
    run_vec(0, '{-20, 5, 7, -3, 0, 2}, "R3 R4 clamp");

    // R12 extremes
    run_vec(0, '{-128, -128, -128, -128, -128, -128}, "R12 all min");
    run_vec(0, '{127, 127, 127, 127, 127, 127}, "R12 all max");
    run_vec(0, '{127, 127, 127, 127, 127, -128}, "R12 mixed");

    // R7 restart discards partial vector
    drive_vec(0, '{50, 50, 50}, 1'b1, -1);
    expect_vec(0, '{1, 9, 3, 4, 5, 6}, "R7 restart");
    drive_vec(0, '{1, 9, 3, 4, 5, 6}, 1'b1, 5);
    finish_vec(0, 1'b1, "R7 start");
    drain(0, "R7 length");

    // R8 early in_last
    drive_vec(0, '{9, 9, 9}, 1'b1, 2);
    finish_vec(0, 1'b0, "R8 early last");
    drain(0, "R8 early last");
    // R8 missing in_first while waiting
    drive_vec(0, '{77, 1, 2, 3, 4, 5}, 1'b0, 5);
    finish_vec(0, 1'b0, "R8 no first");
    drain(0, "R8 no first");
    // R8 Nth element without in_last
    drive_vec(0, '{1, 2, 3, 4, 5, 6}, 1'b1, -1);
    finish_vec(0, 1'b0, "R8 no last");
    drain(0, "R8 no last");
    run_vec(0, '{0, -6, 12, 3, -1, 4}, "R8 recovery");

    // R9 full vector presented during emission is ignored
    expect_vec(0, '{4, 4, 4, 4, 4, 8}, "R9 emit ignore");
    drive_vec(0, '{4, 4, 4, 4, 4, 8}, 1'b1, 5);
    drive_vec(0, '{-100, 90, -90, 80, -80, 70}, 1'b1, 5);
    finish_vec(0, 1'b0, "R9 after stray");
    drain(0, "R9 emit ignore");
    run_vec(0, '{2, 2, 2, 2, 2, 2}, "R9 follow-up");

    // R10 single-element vectors, 5-bit build
    run_vec(2, '{-16}, "R10 single");
    run_vec(2, '{15}, "R10 single");
    run_vec(2, '{-3}, "R10 single");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule